// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This block holds three programmable interval timers for a small audio coprocessor. A shared prescaler divides the base clock by a programmable unit, which is 16 clocks after reset. The third timer (channel 2) takes one tick per unit. Channels 0 and 1 take one tick per eight units, so they run eight times slower. Each channel counts its ticks in an internal stage counter against an 8-bit target period. Each time the stage counter completes a period, the channel bumps a 4-bit output counter.

Software uses the block through an 8-bit register bus with read and write strobes. A control register enables the channels. Three write-only registers set the periods. Three counter registers return the 4-bit count and clear it on each read. A separate reload strobe loads a new prescale unit, and this rescales all three channels at once to change the playback tempo.

Top module: `tri_interval_timer`

## Requirements
- R1: After a synchronous reset all channels are disabled, every output counter reads 0, every period is 256 (stored as 0), the prescale unit is `UNIT_RESET` (16), and `rd_data` is 0.
- R2: A write to offset 0x01 sets the channel enables from its bits: bit 0 enables channel 0, bit 1 enables channel 1, bit 2 enables channel 2. A disabled channel keeps its output counter unchanged.
- R3: Channel 2 ticks once every unit of base clocks. Channels 0 and 1 tick once every 8 units. A pulse on `unit_load` loads `unit_value` as the new unit, with 0 taken as 1, and restarts the prescaler.
- R4: Offsets 0x0A, 0x0B and 0x0C hold the periods of channels 0, 1 and 2. When a channel's stage count completes its period, the output counter goes up by one. A period value of 0 means 256 ticks.
- R5: A read of offset 0x0D, 0x0E or 0x0F returns the counter of channel 0, 1 or 2 in `rd_data[3:0]`, with bits 7:4 at zero, in the cycle after `rd_en`. The same read clears that counter.
- R6: A write to offset 0x0D, 0x0E or 0x0F clears that channel's counter. The write data is ignored.
- R7: Writing a period register with the value it already holds has no effect. Writing a different value applies the new period and restarts that channel's stage count at zero.
- R8: Enabling a channel that was disabled resets its stage count and its output counter to zero.
- R9: If a read or write clear happens in the same cycle as a counter increment, the counter holds 1 afterwards.
- R10: The output counter wraps from 15 to 0.
- R11: A read of any offset other than 0x0D to 0x0F returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register offset within the I/O page |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| unit_load | input | 1 | Loads a new prescale unit |
| unit_value | input | 8 | Prescale unit in base clocks (0 taken as 1) |

## Verification
The hardest case to reach is a counter clear that lands in exactly the cycle in which the counter increments. With a free-running prescaler, that cycle is hard to target from the ports. The bench sets the unit to 1 and gives channel 2 a period of 1, so the channel increments on every clock. It then holds a counter read for several consecutive cycles. Every read after the first must return 1, and that value only appears if the tick that coincides with each clear is kept. The other timing checks first reload the prescaler so its phase is known, then sample halfway between expected increments.

// File: rtl/tit_pkg.sv
package tit_pkg;
  // Register offsets within the I/O page; the per-channel groups are
  // consecutive so channel i sits at base + i.
  localparam logic [7:0] OFS_CTRL     = 8'h01;
  localparam logic [7:0] OFS_PER_BASE = 8'h0A;
  localparam logic [7:0] OFS_CNT_BASE = 8'h0D;
endpackage

// File: rtl/tit_prescaler.sv
module tit_prescaler #(
  parameter int UNIT_W     = 8,
  parameter int UNIT_RESET = 16,
  parameter int SLOW_RATIO = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [UNIT_W-1:0] load_val_i,
  output logic              fast_tick_o,
  output logic              slow_tick_o
);
  localparam int OCT_W = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;
  localparam logic [OCT_W-1:0] OCT_LAST = OCT_W'(SLOW_RATIO - 1);

  logic [UNIT_W-1:0] unit_q;
  logic [UNIT_W-1:0] base_q;
  logic [OCT_W-1:0]  oct_q;
  logic              fast_q;
  logic              slow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_q <= UNIT_W'(UNIT_RESET);
      base_q <= '0;
      oct_q  <= '0;
      fast_q <= 1'b0;
      slow_q <= 1'b0;
    end else if (load_i) begin
      unit_q <= (load_val_i == '0) ? UNIT_W'(1) : load_val_i;
      base_q <= '0;
      oct_q  <= '0;
      fast_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      fast_q <= 1'b0;
      slow_q <= 1'b0;
      if (base_q >= unit_q - UNIT_W'(1)) begin
        base_q <= '0;
        fast_q <= 1'b1;
        if (oct_q == OCT_LAST) begin
          oct_q  <= '0;
          slow_q <= 1'b1;
        end else begin
          oct_q <= oct_q + OCT_W'(1);
        end
      end else begin
        base_q <= base_q + UNIT_W'(1);
      end
    end
  end

  assign fast_tick_o = fast_q;
  assign slow_tick_o = slow_q;

  // R3: a slow tick only ever coincides with a fast tick
  a_r3_slow_on_fast: assert property (@(posedge clk) disable iff (rst)
    slow_q |-> fast_q);
  // R3: a reload leaves no tick pending in the following cycle
  a_r3_reload_quiet: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (!fast_q && !slow_q));
endmodule

// File: rtl/tit_channel.sv
module tit_channel #(
  parameter int PER_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             ctrl_wr_i,
  input  logic             en_bit_i,
  input  logic             per_wr_i,
  input  logic [PER_W-1:0] per_data_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic             en_q;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] stage_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;
  logic             per_change;
  logic             stage_done;
  logic             inc;

  assign rise       = ctrl_wr_i && en_bit_i && !en_q;
  assign per_change = per_wr_i && (per_data_i != per_q);
  // Stored period 0 stands for 2**PER_W: the PER_W-bit sum wraps to 0 there.
  assign stage_done = (PER_W'(stage_q + PER_W'(1)) == per_q);
  assign inc        = en_q && tick_i && stage_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      per_q   <= '0;
      stage_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (ctrl_wr_i) en_q <= en_bit_i;
      if (per_change) per_q <= per_data_i;
      if (rise) begin
        stage_q <= '0;
        cnt_q   <= '0;
      end else begin
        if (per_change)
          stage_q <= '0;
        else if (en_q && tick_i)
          stage_q <= stage_done ? '0 : stage_q + PER_W'(1);
        if (clr_i)
          cnt_q <= inc ? CNT_W'(1) : '0;
        else if (inc)
          cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_o = cnt_q;

  // R2: a disabled channel, untouched by clear or enable, holds its count
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !clr_i && !(ctrl_wr_i && en_bit_i)) |=> $stable(cnt_q));
  // R4: the stage count stays below a nonzero period
  a_r4_stage_below_period: assert property (@(posedge clk) disable iff (rst)
    (per_q != '0) |-> (stage_q < per_q));
  // R8: enabling from off starts the channel from zero
  a_r8_enable_clears: assert property (@(posedge clk) disable iff (rst)
    rise |=> (cnt_q == '0 && stage_q == '0));
  // R9: after a clear the counter holds at most the coincident tick
  a_r9_clear_keeps_tick: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !rise) |=> (cnt_q <= CNT_W'(1)));
  // R10: without clear or enable the counter moves by at most one, wrapping
  a_r10_single_step: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !rise) |=> (cnt_q == $past(cnt_q) ||
                           cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 8,
  parameter int UNIT_W     = 8,
  parameter int UNIT_RESET = 16,
  parameter int SLOW_RATIO = 8,
  parameter int NUM_CH     = 3,
  parameter int NUM_SLOW   = 2,
  parameter int CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              unit_load,
  input  logic [UNIT_W-1:0] unit_value
);
  import tit_pkg::*;

  localparam int PER_W = DATA_W;
  localparam int PAD_W = DATA_W - CNT_W;

  logic             fast_tick;
  logic             slow_tick;
  logic             ctrl_wr;
  logic [CNT_W-1:0] cnt [NUM_CH];
  logic [NUM_CH-1:0] cnt_hit;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_q;

  tit_prescaler #(
    .UNIT_W(UNIT_W), .UNIT_RESET(UNIT_RESET), .SLOW_RATIO(SLOW_RATIO)
  ) u_presc (
    .clk(clk), .rst(rst),
    .load_i(unit_load), .load_val_i(unit_value),
    .fast_tick_o(fast_tick), .slow_tick_o(slow_tick)
  );

  assign ctrl_wr = wr_en && (bus_addr == ADDR_W'(OFS_CTRL));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic tick;
    logic per_wr;
    if (i < NUM_SLOW) begin : g_slow
      assign tick = slow_tick;
    end else begin : g_fast
      assign tick = fast_tick;
    end
    assign per_wr     = wr_en && (bus_addr == ADDR_W'(OFS_PER_BASE) + ADDR_W'(i));
    assign cnt_hit[i] = (bus_addr == ADDR_W'(OFS_CNT_BASE) + ADDR_W'(i));

    tit_channel #(.PER_W(PER_W), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst),
      .tick_i(tick),
      .ctrl_wr_i(ctrl_wr),
      .en_bit_i(wr_data[i]),
      .per_wr_i(per_wr),
      .per_data_i(wr_data),
      .clr_i((rd_en || wr_en) && cnt_hit[i]),
      .cnt_o(cnt[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (cnt_hit[i]) rd_mux = {{PAD_W{1'b0}}, cnt[i]};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_en ? rd_mux : '0;
  end

  assign rd_data = rd_q;

  // R11: reads outside the counter offsets return zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cnt_hit == '0) |=> (rd_q == '0));
  // R5: at most one counter offset decodes at a time
  a_r5_single_decode: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cnt_hit));
endmodule

// File: tb/tri_interval_timer_bench.sv
module tri_interval_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       unit_load = 1'b0;
  logic [7:0] unit_value = '0;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int t_en = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tri_interval_timer u_tri_interval_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .unit_load(unit_load), .unit_value(unit_value)
  );

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output int v);
    @(negedge clk);
    bus_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // period, then aligned prescaler reload, then enable of channel ch
  task automatic start_timer(int ch, logic [7:0] per, logic [7:0] unit);
    bus_write(8'h01, 8'h00);
    bus_write(8'h0A + 8'(ch), per);
    @(negedge clk);
    unit_load = 1'b1; unit_value = unit;
    @(negedge clk);
    unit_load = 1'b0;
    bus_write(8'h01, 8'(1 << ch));
    t_en = cyc;
  endtask

  task automatic t_reset();
    int v;
    for (int i = 0; i < 3; i++) begin
      bus_read(8'h0D + 8'(i), v);
      chk("R1 counter after reset", v, 0);
    end
    chk("R1 rd_data idle", int'(rd_data), 0);
  endtask

  task automatic t_fast_basic();
    int v;
    start_timer(2, 8'd4, 8'd16);
    wait_until(t_en + 224);
    bus_read(8'h0F, v);
    chk("R4 ch2 unit16 period4", v, 3);
    bus_read(8'h0F, v);
    chk("R5 read clears", v, 0);
    bus_read(8'h05, v);
    chk("R11 unmapped read", v, 0);
  endtask

  task automatic t_slow();
    int v;
    start_timer(0, 8'd2, 8'd16);
    wait_until(t_en + 620);
    bus_read(8'h0D, v);
    chk("R3 ch0 eight-unit prescale", v, 2);
    bus_read(8'h0E, v);
    chk("R2 ch1 disabled stays 0", v, 0);
  endtask

  task automatic t_period_zero();
    int v;
    start_timer(2, 8'd0, 8'd0);
    wait_until(t_en + 896);
    bus_read(8'h0F, v);
    chk("R4 period 0 means 256, R3 unit 0 as 1", v, 3);
  endtask

  task automatic t_wrap();
    int v;
    start_timer(2, 8'd2, 8'd8);
    wait_until(t_en + 280);
    bus_read(8'h0F, v);
    chk("R10 wrap after 17 increments", v, 1);
  endtask

  task automatic t_write_clear();
    int v;
    start_timer(2, 8'd4, 8'd16);
    wait_until(t_en + 224);
    bus_write(8'h0F, 8'hFF);
    bus_read(8'h0F, v);
    chk("R6 write clears counter", v, 0);
  endtask

  task automatic t_period_rewrite();
    int v;
    start_timer(2, 8'd8, 8'd16);
    wait_until(t_en + 200);
    bus_write(8'h0C, 8'd8);
    wait_until(t_en + 280);
    bus_read(8'h0F, v);
    chk("R7 same-value write ignored", v, 2);
    wait_until(t_en + 300);
    bus_write(8'h0C, 8'd4);
    wait_until(t_en + 440);
    bus_read(8'h0F, v);
    chk("R7 new period applied", v, 2);
  endtask

  task automatic t_enable();
    int v;
    start_timer(2, 8'd4, 8'd16);
    wait_until(t_en + 224);
    bus_write(8'h01, 8'h00);
    wait_until(t_en + 500);
    bus_read(8'h0F, v);
    chk("R2 disabled channel holds", v, 3);
    start_timer(2, 8'd4, 8'd16);
    wait_until(t_en + 224);
    bus_write(8'h01, 8'h00);
    bus_write(8'h01, 8'h04);
    bus_read(8'h0F, v);
    chk("R8 re-enable clears counter", v, 0);
  endtask

  task automatic t_coincide();
    start_timer(2, 8'd1, 8'd1);
    wait_until(t_en + 10);
    @(negedge clk);
    bus_addr = 8'h0F; rd_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k >= 1) chk("R9 tick kept on read clear", int'(rd_data), 1);
    end
    rd_en = 1'b0;
    bus_write(8'h01, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fast_basic();
    t_slow();
    t_period_zero();
    t_wrap();
    t_write_clear();
    t_period_rewrite();
    t_enable();
    t_coincide();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule